// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage In-Order Pipeline

This block sits beside a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) and makes every fault precise. Fetch may report a page fault or a protection violation. Decode may report an illegal opcode. Execute may report an arithmetic overflow. The memory stage may report a data page fault or a data protection violation. Write-back never faults. The controller keeps a shadow record for each instruction in decode, execute and memory. A fault flag is attached to the record of the instruction that raised it. The record then travels down the pipe with that instruction until the instruction reaches the memory/write-back boundary.

Only at that boundary is a trap taken. The instruction and everything younger are squashed into bubbles, the faulting PC and a 3-bit cause are latched, and fetch is redirected to a fixed handler address. While the handler runs, further traps are disabled. A return request sends fetch back to the saved PC and enables traps again. An external interrupt, gated by an enable input, is attached to the oldest valid instruction at the same boundary. That instruction is squashed and restarted after the return.

Top module: `precise_trap_ctrl`

## Requirements
- R1: After reset, trap_o, redirect_o and in_handler_o are 0, flush_o is 0, and epc_o and cause_o are 0.
- R2: Cause codes are 1 fetch page fault, 2 fetch protection violation, 3 illegal opcode, 4 arithmetic overflow, 5 data page fault, 6 data protection violation and 7 interrupt. Within one stage, a page fault beats a protection violation.
- R3: A trap is raised only for a valid instruction that holds a cause while it sits in the memory stage and adv_i is high. A fault raised in fetch takes its trap on the fourth advancing cycle, counting the one in which it was reported.
- R4: When faults are in flight for several instructions, the trap reports the oldest one. The records of younger instructions are discarded by the squash.
- R5: If one instruction collects faults in several stages, the cause recorded first (the earliest stage) is kept.
- R6: In the trap cycle, trap_o and redirect_o are 1, redirect_pc_o equals HANDLER_PC and flush_o is all ones, so all four squashable stages are squashed.
- R7: On the clock edge that ends a trap cycle, epc_o takes the PC of the trapping instruction, cause_o takes its cause, and in_handler_o becomes 1.
- R8: While in_handler_o is 1, no trap is raised for faults or interrupts, and epc_o and cause_o hold their values.
- R9: When ret_i is high while in_handler_o is 1, redirect_o is 1, redirect_pc_o equals epc_o and flush_o is all ones in that cycle, and in_handler_o falls at the next edge. When in_handler_o is 0, ret_i has no effect.
- R10: An interrupt is taken with cause 7 when irq_i and irq_en_i are high, the memory stage holds a valid instruction with no cause, and adv_i is high. epc_o then takes that instruction's PC. When irq_en_i is low, the interrupt has no effect. A fault in the memory-stage record wins over a simultaneous interrupt.
- R11: While adv_i is low, no record moves and no trap is raised.
- R12: Fault flags that arrive with a bubble (if_valid_i low) are never recorded and cannot cause a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Pipeline advances this cycle |
| if_valid_i | input | 1 | Fetch stage holds a real instruction |
| if_pc_i | input | PC_W | PC of the fetch-stage instruction |
| if_page_fault_i | input | 1 | Instruction fetch page fault |
| if_prot_fault_i | input | 1 | Instruction fetch protection violation |
| id_illegal_i | input | 1 | Decode found an illegal opcode |
| ex_overflow_i | input | 1 | Execute found an arithmetic overflow |
| mem_page_fault_i | input | 1 | Data access page fault |
| mem_prot_fault_i | input | 1 | Data access protection violation |
| irq_i | input | 1 | External interrupt request |
| irq_en_i | input | 1 | Global interrupt enable |
| ret_i | input | 1 | Return from handler |
| trap_o | output | 1 | A trap is taken this cycle |
| redirect_o | output | 1 | Fetch must restart at redirect_pc_o |
| redirect_pc_o | output | PC_W | New fetch address, valid with redirect_o |
| flush_o | output | 4 | Squash mask: bit0 fetch, bit1 decode, bit2 execute, bit3 memory |
| epc_o | output | PC_W | Saved PC of the trapping instruction |
| cause_o | output | 3 | Saved cause code |
| in_handler_o | output | 1 | Handler running; traps disabled |

## Verification
The hard cases are cycles in which several faults arrive together. One case is fetch, decode and execute all raising faults on different instructions in the same cycle. Another is an interrupt arriving in the same cycle as a memory-stage fault. The bench sets up both cases on purpose and also scatters them at random over thousands of cycles. A behavioural reference model follows each instruction's record in integer arrays, and every output is compared on every clock. A wrong choice shows up as a cause or saved PC belonging to a younger instruction, or as an interrupt code where a fault code is expected.

// File: rtl/ptrap_pkg.sv
`timescale 1ns/1ps
package ptrap_pkg;
  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    C_NONE = 3'd0,
    C_IPF  = 3'd1,
    C_IPV  = 3'd2,
    C_ILL  = 3'd3,
    C_OVF  = 3'd4,
    C_DPF  = 3'd5,
    C_DPV  = 3'd6,
    C_IRQ  = 3'd7
  } cause_e;

  // Page fault outranks protection violation inside one stage (R2).
  function automatic logic [CAUSE_W-1:0] pick_fault(
    input logic pf, input logic pv,
    input logic [CAUSE_W-1:0] pf_code, input logic [CAUSE_W-1:0] pv_code);
    if (pf)      return pf_code;
    else if (pv) return pv_code;
    else         return C_NONE;
  endfunction

  // An earlier-recorded cause is never overwritten (R5).
  function automatic logic [CAUSE_W-1:0] keep_first(
    input logic [CAUSE_W-1:0] held, input logic [CAUSE_W-1:0] fresh);
    return (held != C_NONE) ? held : fresh;
  endfunction
endpackage

// File: rtl/ptrap_tag_pipe.sv
`timescale 1ns/1ps
module ptrap_tag_pipe
  import ptrap_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            adv_i,
  input  logic                            kill_i,
  input  logic                            ent_valid_i,
  input  logic [PC_W-1:0]                 ent_pc_i,
  input  logic [CAUSE_W-1:0]              ent_cause_i,
  input  logic [DEPTH-1:0][CAUSE_W-1:0]   slot_cause_i,
  output logic                            tail_v_o,
  output logic [PC_W-1:0]                 tail_pc_o,
  output logic [CAUSE_W-1:0]              tail_cause_o
);
  logic [DEPTH-1:0]               slot_v;
  logic [DEPTH-1:0][PC_W-1:0]     slot_pc;
  logic [DEPTH-1:0][CAUSE_W-1:0]  slot_c;
  logic [DEPTH-1:0][CAUSE_W-1:0]  merged_c;
  logic [DEPTH-1:0]               src_v;
  logic [DEPTH-1:0][PC_W-1:0]     src_pc;
  logic [DEPTH-1:0][CAUSE_W-1:0]  src_c;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    // A cause only sticks to a real instruction.
    assign merged_c[k] = slot_v[k] ? keep_first(slot_c[k], slot_cause_i[k]) : C_NONE;

    if (k == 0) begin : g_head
      assign src_v[k]  = ent_valid_i;
      assign src_pc[k] = ent_pc_i;
      assign src_c[k]  = ent_valid_i ? ent_cause_i : C_NONE;
    end else begin : g_body
      assign src_v[k]  = slot_v[k-1];
      assign src_pc[k] = slot_pc[k-1];
      assign src_c[k]  = merged_c[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_v[k]  <= 1'b0;
        slot_pc[k] <= '0;
        slot_c[k]  <= C_NONE;
      end else if (kill_i) begin
        slot_v[k]  <= 1'b0;
        slot_c[k]  <= C_NONE;
      end else if (adv_i) begin
        slot_v[k]  <= src_v[k];
        slot_pc[k] <= src_pc[k];
        slot_c[k]  <= src_c[k];
      end
    end
  end

  assign tail_v_o     = slot_v[DEPTH-1];
  assign tail_pc_o    = slot_pc[DEPTH-1];
  assign tail_cause_o = merged_c[DEPTH-1];
endmodule

// File: rtl/ptrap_ctl.sv
`timescale 1ns/1ps
module ptrap_ctl
  import ptrap_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_i,
  input  logic               tail_v_i,
  input  logic [PC_W-1:0]    tail_pc_i,
  input  logic [CAUSE_W-1:0] tail_cause_i,
  input  logic               irq_i,
  input  logic               irq_en_i,
  input  logic               ret_i,
  output logic               fault_take_o,
  output logic               irq_take_o,
  output logic               ret_take_o,
  output logic               trap_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               in_handler_o
);
  logic               armed_q;
  logic [PC_W-1:0]    epc_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               boundary;

  // The oldest instruction crosses into write-back this cycle.
  assign boundary     = armed_q && adv_i && tail_v_i;
  assign fault_take_o = boundary && (tail_cause_i != C_NONE);
  assign irq_take_o   = boundary && (tail_cause_i == C_NONE) && irq_i && irq_en_i;
  assign ret_take_o   = !armed_q && ret_i;

  assign trap_o        = fault_take_o || irq_take_o;
  assign redirect_o    = trap_o || ret_take_o;
  assign redirect_pc_o = trap_o ? HANDLER_PC : epc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      epc_q   <= '0;
      cause_q <= C_NONE;
    end else begin
      if (trap_o) begin
        armed_q <= 1'b0;
        epc_q   <= tail_pc_i;
        cause_q <= fault_take_o ? tail_cause_i : C_IRQ;
      end else if (ret_take_o) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign epc_o        = epc_q;
  assign cause_o      = cause_q;
  assign in_handler_o = !armed_q;
endmodule

// File: rtl/precise_trap_ctrl.sv
`timescale 1ns/1ps
module precise_trap_ctrl
  import ptrap_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_i,
  input  logic               if_valid_i,
  input  logic [PC_W-1:0]    if_pc_i,
  input  logic               if_page_fault_i,
  input  logic               if_prot_fault_i,
  input  logic               id_illegal_i,
  input  logic               ex_overflow_i,
  input  logic               mem_page_fault_i,
  input  logic               mem_prot_fault_i,
  input  logic               irq_i,
  input  logic               irq_en_i,
  input  logic               ret_i,
  output logic               trap_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic [3:0]         flush_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               in_handler_o
);
  // Shadow records for decode, execute and memory.
  localparam int N_TRACK = 3;
  localparam int N_SQUASH = N_TRACK + 1;

  logic [CAUSE_W-1:0]              fetch_cause;
  logic [N_TRACK-1:0][CAUSE_W-1:0] stage_cause;
  logic                            tail_v;
  logic [PC_W-1:0]                 tail_pc;
  logic [CAUSE_W-1:0]              tail_cause;
  logic                            fault_take;
  logic                            irq_take;
  logic                            ret_take;

  assign fetch_cause    = pick_fault(if_page_fault_i, if_prot_fault_i, C_IPF, C_IPV);
  assign stage_cause[0] = id_illegal_i  ? C_ILL : C_NONE;
  assign stage_cause[1] = ex_overflow_i ? C_OVF : C_NONE;
  assign stage_cause[2] = pick_fault(mem_page_fault_i, mem_prot_fault_i, C_DPF, C_DPV);

  ptrap_tag_pipe #(.PC_W(PC_W), .DEPTH(N_TRACK)) u_tags (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv_i        (adv_i),
    .kill_i       (redirect_o),
    .ent_valid_i  (if_valid_i),
    .ent_pc_i     (if_pc_i),
    .ent_cause_i  (fetch_cause),
    .slot_cause_i (stage_cause),
    .tail_v_o     (tail_v),
    .tail_pc_o    (tail_pc),
    .tail_cause_o (tail_cause)
  );

  ptrap_ctl #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .adv_i         (adv_i),
    .tail_v_i      (tail_v),
    .tail_pc_i     (tail_pc),
    .tail_cause_i  (tail_cause),
    .irq_i         (irq_i),
    .irq_en_i      (irq_en_i),
    .ret_i         (ret_i),
    .fault_take_o  (fault_take),
    .irq_take_o    (irq_take),
    .ret_take_o    (ret_take),
    .trap_o        (trap_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .epc_o         (epc_o),
    .cause_o       (cause_o),
    .in_handler_o  (in_handler_o)
  );

  // Any redirect squashes every stage in front of write-back.
  assign flush_o = redirect_o ? {N_SQUASH{1'b1}} : '0;
endmodule

// File: rtl/ptrap_checker.sv
`timescale 1ns/1ps
module ptrap_checker #(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input logic            clk,
  input logic            rst_n,
  input logic            adv_i,
  input logic            ret_i,
  input logic            trap_o,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o,
  input logic [3:0]      flush_o,
  input logic [PC_W-1:0] epc_o,
  input logic [2:0]      cause_o,
  input logic            in_handler_o,
  input logic            tail_v,
  input logic [PC_W-1:0] tail_pc,
  input logic            fault_take,
  input logic            irq_take,
  input logic            ret_take
);
  a_r6_trap_squashes_to_handler: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (flush_o == 4'hF) && (redirect_pc_o == HANDLER_PC));

  a_r7_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> (epc_o == $past(tail_pc)) && in_handler_o && (cause_o != 3'd0));

  a_r8_no_trap_in_handler: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler_o |-> !trap_o);

  a_r8_saved_state_held: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler_o |=> $stable(epc_o) && $stable(cause_o));

  a_r9_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && in_handler_o) |-> redirect_o && (redirect_pc_o == epc_o) && (flush_o == 4'hF));

  a_r9_return_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && in_handler_o) |=> !in_handler_o);

  a_r9_return_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !in_handler_o && !trap_o) |-> !redirect_o);

  a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_take, irq_take, ret_take}));

  a_r10_irq_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (cause_o == 3'd7));

  a_r11_no_trap_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |-> !trap_o);

  a_r4_trap_needs_instr: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> tail_v);
endmodule

bind precise_trap_ctrl ptrap_checker #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_chk (.*);

// File: tb/test_precise_trap_ctrl.sv
`timescale 1ns/1ps
module test_precise_trap_ctrl;
  localparam int PC_W = 32;
  localparam logic [PC_W-1:0] HPC = 32'h0000_0180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adv_i = 0, if_valid_i = 0, if_page_fault_i = 0, if_prot_fault_i = 0;
  logic id_illegal_i = 0, ex_overflow_i = 0, mem_page_fault_i = 0, mem_prot_fault_i = 0;
  logic irq_i = 0, irq_en_i = 0, ret_i = 0;
  logic [PC_W-1:0] if_pc_i = '0;
  logic trap_o, redirect_o, in_handler_o;
  logic [PC_W-1:0] redirect_pc_o, epc_o;
  logic [3:0] flush_o;
  logic [2:0] cause_o;

  always #5 clk = ~clk;

  precise_trap_ctrl #(.PC_W(PC_W), .HANDLER_PC(HPC)) i_precise_trap_ctrl (.*);

  int n_cmp = 0, n_bad = 0;
  // Reference model: index 1 decode, 2 execute, 3 memory.
  int mv[1:3], mpc[1:3], mc[1:3];
  int m_en = 1, m_epc = 0, m_cause = 0;
  int pc_ctr = 32'h1000;

  function automatic void check(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endfunction

  task automatic step(input bit adv, input bit ifv, input bit ipf, input bit ipv,
                      input bit ill, input bit ovf, input bit dpf, input bit dpv,
                      input bit irq, input bit ien, input bit ret);
    int mem_c, e_trap, e_fault, e_irq, e_ret, e_red, ifc;
    @(negedge clk);
    adv_i = adv; if_valid_i = ifv; if_pc_i = pc_ctr;
    if_page_fault_i = ipf; if_prot_fault_i = ipv; id_illegal_i = ill;
    ex_overflow_i = ovf; mem_page_fault_i = dpf; mem_prot_fault_i = dpv;
    irq_i = irq; irq_en_i = ien; ret_i = ret;
    #1;
    mem_c = 0;
    if (mv[3] != 0) mem_c = (mc[3] != 0) ? mc[3] : (dpf ? 5 : (dpv ? 6 : 0));
    e_fault = (m_en != 0 && adv && mv[3] != 0 && mem_c != 0) ? 1 : 0;
    e_irq   = (m_en != 0 && adv && mv[3] != 0 && mem_c == 0 && irq && ien) ? 1 : 0;
    e_ret   = (m_en == 0 && ret) ? 1 : 0;
    e_trap  = e_fault | e_irq;
    e_red   = e_trap | e_ret;
    check("R3", "trap_o", trap_o, e_trap);
    check("R6", "redirect_o", redirect_o, e_red);
    check("R6", "flush_o", flush_o, e_red ? 4'hF : 4'h0);
    if (e_red != 0) check(e_trap != 0 ? "R6" : "R9", "redirect_pc_o", redirect_pc_o,
                          e_trap != 0 ? HPC : m_epc);
    check("R7", "epc_o", epc_o, m_epc);
    check("R2", "cause_o", cause_o, m_cause);
    check("R8", "in_handler_o", in_handler_o, m_en == 0);
    @(posedge clk);
    if (e_trap != 0) begin m_epc = mpc[3]; m_cause = (e_fault != 0) ? mem_c : 7; m_en = 0; end
    else if (e_ret != 0) m_en = 1;
    if (e_red != 0) begin
      for (int k = 1; k <= 3; k++) begin mv[k] = 0; mc[k] = 0; end
    end else if (adv) begin
      mv[3] = mv[2]; mpc[3] = mpc[2];
      mc[3] = (mv[2] != 0) ? ((mc[2] != 0) ? mc[2] : (ovf ? 4 : 0)) : 0;
      mv[2] = mv[1]; mpc[2] = mpc[1];
      mc[2] = (mv[1] != 0) ? ((mc[1] != 0) ? mc[1] : (ill ? 3 : 0)) : 0;
      ifc = ipf ? 1 : (ipv ? 2 : 0);
      mv[1] = ifv; mpc[1] = pc_ctr; mc[1] = ifv ? ifc : 0;
    end
    if (adv || e_red != 0) pc_ctr = pc_ctr + 4;
  endtask

  task automatic run(input int n);   // plain advancing instructions
    for (int i = 0; i < n; i++) step(1,1,0,0,0,0,0,0,0,0,0);
  endtask

  task automatic go_back();
    step(0,0,0,0,0,0,0,0,0,0,1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 1; k <= 3; k++) begin mv[k] = 0; mpc[k] = 0; mc[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state observed on an idle stalled cycle.
    step(0,0,0,0,0,0,0,0,0,0,0);
    run(5);
    // R3 R6 R7: fetch page fault traps on its fourth advancing cycle.
    step(1,1,1,0,0,0,0,0,0,0,0);
    run(4);
    // R8: faults and interrupt ignored in handler.
    step(1,1,0,1,1,1,1,0,1,1,0);
    run(4);
    step(1,1,0,0,0,0,1,0,1,1,0);
    // R9: return redirects to saved PC.
    go_back();
    // R9: return outside handler ignored.
    go_back();
    run(3);
    // R4: faults in fetch, decode and execute together; execute is oldest.
    step(1,1,0,1,1,1,0,0,0,0,0);
    run(3);
    go_back();
    run(3);
    // R5: fetch protection fault then illegal flagged on the same instruction.
    step(1,1,0,1,0,0,0,0,0,0,0);
    step(1,1,0,0,1,0,0,0,0,0,0);
    step(1,1,0,0,0,1,0,0,0,0,0);
    step(1,1,0,0,0,0,1,0,0,0,0);
    go_back();
    run(3);
    // R10: interrupt with enable, then masked, then data fault beating it.
    step(1,1,0,0,0,0,0,0,1,1,0);
    go_back();
    run(3);
    step(1,1,0,0,0,0,0,0,1,0,0);
    step(1,1,0,0,0,0,0,1,1,1,0);
    go_back();
    run(3);
    // R11: stall while memory holds a faulting record.
    step(1,1,0,0,0,1,0,0,0,0,0);
    run(1);
    for (int i = 0; i < 3; i++) step(0,1,0,0,0,0,0,0,0,0,0);
    step(1,1,0,0,0,0,0,0,0,0,0);
    go_back();
    // R12: bubble carrying fault flags.
    step(1,0,1,1,0,0,0,0,0,0,0);
    run(5);
    // Mixed traffic; every output compared each cycle.
    for (int i = 0; i < 4000; i++) begin
      bit ien = ((i / 200) % 2) == 0;
      bit rt  = (m_en == 0) ? ($urandom % 5 == 0) : ($urandom % 40 == 0);
      step($urandom % 8 != 0, $urandom % 6 != 0, $urandom % 25 == 0, $urandom % 25 == 0,
           $urandom % 25 == 0, $urandom % 25 == 0, $urandom % 30 == 0, $urandom % 30 == 0,
           $urandom % 15 == 0, ien, rt);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule